// File: doc/BRIEF.md
# Prescaled Up/Down Alarm Timer

The block is a single general-purpose timer. A 16-bit programmable prescaler divides the clock and paces a 64-bit time base. The time base counts up or down and can be halted and resumed without losing its value. Software can also load it at once from a programmed reload value. The count is compared with a 64-bit alarm value. On a match the block raises a sticky level interrupt and a one-cycle pulse interrupt, and it can optionally reload the count at the same edge.

Software drives a write-only register port. Each write carries an address and a 32-bit data word. The live count is visible on a dedicated output. A separate input clears the level interrupt.

Top module: `updown_alarm_timer`

## Requirements
- R1: The divider register (address 1, bits 15:0) sets the step period. A value D from 2 to 65535 makes the count change once every D clock cycles. A value of 0 gives a period of 65536 cycles, and a value of 1 gives a period of 2 cycles.
- R2: Control bit 1 (address 0) selects the direction. With the bit set, the count rises by one per step; with it clear, the count falls by one. Either way the count wraps modulo 2^64.
- R3: Control bit 0 is the run enable. While it is clear, the count and the prescaler phase both hold. Setting it again resumes from the held phase.
- R4: Any write to the divider register restarts the prescaler phase. The first step after such a write lands D cycles after the write edge, where D is the effective period.
- R5: Control bit 3 arms the alarm. While the timer runs and the alarm is armed, a count equal to the alarm value (low word at address 2, high word at address 3) fires the alarm at the next edge. Firing clears the arm bit, and this clear takes priority over a control write in the same cycle. A disarmed alarm never fires.
- R6: With control bit 2 set, a firing alarm loads the reload value (low word at address 4, high word at address 5) into the count at the edge where the interrupts rise. With the bit clear, counting continues from the alarm value.
- R7: A write of any data to address 6 loads the reload value into the count at that write edge, whether or not the timer runs.
- R8: `irq_pulse_o` is high for exactly one clock cycle per alarm.
- R9: `irq_level_o` rises with the alarm pulse and stays high until `int_clr_i` is sampled high. If an alarm and a clear arrive in the same cycle, the alarm wins.
- R10: After reset, the count is 0, both interrupts are low, the timer is halted and disarmed, and every register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| int_clr_i | input | 1 | Clears the level interrupt |
| count_o | output | 64 | Current time-base value |
| irq_level_o | output | 1 | Sticky alarm interrupt |
| irq_pulse_o | output | 1 | One-cycle alarm interrupt |

## Verification
A write becomes visible at the first rising edge after it is presented. A step lands D edges after the edge that enabled the timer or rewrote the divider. Both interrupts rise one edge after the count first equals the alarm value. An instant reload shows up on the count at the write edge itself. The bench drives every input on falling edges and counts whole cycles from the edge that committed each write. It samples on the falling edge just after the edge where each result is due, and where the timing matters it also samples one edge earlier to catch a result that arrives early.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;
  localparam int A_CTRL        = 0;
  localparam int A_DIV         = 1;
  localparam int A_ALARM_BASE  = 2;
  localparam int A_RELOAD_BASE = 4;
  localparam int A_LOAD        = 6;

  // bit 3..0 of the control word
  typedef struct packed {
    logic arm;
    logic auto_rl;
    logic up;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import updown_timer_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              alarm_hit_i,
  output ctrl_t             ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              div_wr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  alarm_o,
  output logic [CNT_W-1:0]  reload_o
);
  localparam int NWORDS = CNT_W / DATA_W;

  logic ctrl_wr;
  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
  assign div_wr_o = wr_en_i && (wr_addr_i == ADDR_W'(A_DIV));
  assign load_o   = wr_en_i && (wr_addr_i == ADDR_W'(A_LOAD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_o.run     <= wr_data_i[0];
        ctrl_o.up      <= wr_data_i[1];
        ctrl_o.auto_rl <= wr_data_i[2];
      end
      // firing disarms, even against a same-cycle rearm
      if (alarm_hit_i)  ctrl_o.arm <= 1'b0;
      else if (ctrl_wr) ctrl_o.arm <= wr_data_i[3];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_o <= '0;
    else if (div_wr_o) div_o <= wr_data_i[DIV_W-1:0];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alarm_o[w*DATA_W +: DATA_W]  <= '0;
        reload_o[w*DATA_W +: DATA_W] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(A_ALARM_BASE + w))
          alarm_o[w*DATA_W +: DATA_W] <= wr_data_i;
        if (wr_addr_i == ADDR_W'(A_RELOAD_BASE + w))
          reload_o[w*DATA_W +: DATA_W] <= wr_data_i;
      end
    end
  end

  assert_arm_selfclear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit_i |=> !ctrl_o.arm);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pcnt_q, term;

  // 0 -> full range, 1 -> treated as 2
  always_comb begin
    if (div_i == '0)                    term = '1;
    else if (div_i == DIV_W'(1))        term = DIV_W'(1);
    else                                term = div_i - DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (run_i)     pcnt_q <= (pcnt_q == term) ? '0 : pcnt_q + DIV_W'(1);
  end

  assign tick_o = run_i && !restart_i && (pcnt_q == term);

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_phase_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= term);
  assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             up_i,
  input  logic             auto_rl_i,
  input  logic             arm_i,
  input  logic             load_i,
  input  logic             int_clr_i,
  input  logic [CNT_W-1:0] alarm_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             irq_level_o,
  output logic             irq_pulse_o
);
  assign hit_o = run_i && arm_i && (cnt_o == alarm_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (load_i)              cnt_o <= reload_i;
    else if (hit_o && auto_rl_i)  cnt_o <= reload_i;
    else if (tick_i)              cnt_o <= up_i ? cnt_o + CNT_W'(1) : cnt_o - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_level_o <= 1'b0;
      irq_pulse_o <= 1'b0;
    end else begin
      irq_pulse_o <= hit_o;
      if (hit_o)          irq_level_o <= 1'b1;
      else if (int_clr_i) irq_level_o <= 1'b0;
    end
  end

  assert_halt_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_o));
  assert_instant_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(reload_i));
  assert_auto_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && auto_rl_i) |=> cnt_o == $past(reload_i));
  assert_step_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && up_i && !load_i && !(hit_o && auto_rl_i)) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |=> !irq_pulse_o);
  assert_level_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o && !int_clr_i) |=> irq_level_o);
  assert_level_with_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_level_o) |-> irq_pulse_o);
endmodule

// File: rtl/updown_alarm_timer.sv
module updown_alarm_timer
  import updown_timer_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              int_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_level_o,
  output logic              irq_pulse_o
);
  ctrl_t            ctrl;
  logic [DIV_W-1:0] div;
  logic             div_wr, load, tick, hit;
  logic [CNT_W-1:0] alarm, reload;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .alarm_hit_i(hit), .ctrl_o(ctrl), .div_o(div),
    .div_wr_o(div_wr), .load_o(load), .alarm_o(alarm), .reload_o(reload)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .restart_i(div_wr),
    .div_i(div), .tick_o(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .run_i(ctrl.run),
    .up_i(ctrl.up), .auto_rl_i(ctrl.auto_rl), .arm_i(ctrl.arm), .load_i(load),
    .int_clr_i(int_clr_i), .alarm_i(alarm), .reload_i(reload), .cnt_o(count_o),
    .hit_o(hit), .irq_level_o(irq_level_o), .irq_pulse_o(irq_pulse_o)
  );
endmodule

// File: tb/sim_updown_alarm_timer.sv
module sim_updown_alarm_timer;
  logic        clk = 0, rst_ni = 0, wr_en = 0, int_clr = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [63:0] count;
  logic        irq_lvl, irq_pls;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  updown_alarm_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .int_clr_i(int_clr), .count_o(count),
    .irq_level_o(irq_lvl), .irq_pulse_o(irq_pls)
  );

  typedef struct packed {
    logic [15:0] div;
    logic        up;
    logic [63:0] init;
    logic [31:0] n;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd2, 1'b1, 64'd0,                  32'd10,    64'd5},
    '{16'd3, 1'b0, 64'd100,                32'd9,     64'd97},
    '{16'd0, 1'b1, 64'd5,                  32'd65536, 64'd6},
    '{16'd1, 1'b1, 64'd0,                  32'd7,     64'd3},
    '{16'd5, 1'b0, 64'd0,                  32'd10,    64'hFFFF_FFFF_FFFF_FFFE},
    '{16'd4, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'd4,    64'd0},
    '{16'd2, 1'b1, 64'h0000_0000_FFFF_FFFF, 32'd2,    64'h1_0000_0000},
    '{16'd7, 1'b1, 64'd20,                 32'd20,    64'd22}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write commits at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk(count == 0, "R10 count", count, 0);
    chk(irq_lvl == 0 && irq_pls == 0, "R10 irqs", {irq_lvl, irq_pls}, 0);

    // table of divider/direction patterns
    for (int i = 0; i < 8; i++) begin
      wr(0, 0);
      wr(4, VECS[i].init[31:0]);
      wr(5, VECS[i].init[63:32]);
      wr(6, 0);
      wr(1, {16'd0, VECS[i].div});
      wr(0, VECS[i].up ? 32'd3 : 32'd1);
      repeat (VECS[i].n) @(negedge clk);
      chk(count == VECS[i].exp, $sformatf("R1/R2 vector %0d", i), count, VECS[i].exp);
    end

    // R7 instant load while halted
    wr(0, 0);
    wr(4, 32'h1234_5678);
    wr(5, 32'hABCD_0000);
    wr(6, 0);
    chk(count == 64'hABCD_0000_1234_5678, "R7 instant load", count, 64'hABCD_0000_1234_5678);

    // R3 halt/resume keeps phase, R4 divider write restarts phase
    wr(0, 0); wr(4, 0); wr(5, 0); wr(6, 0); wr(1, 4); wr(0, 3);
    repeat (6) @(negedge clk);
    wr(0, 0);
    repeat (10) @(negedge clk);
    chk(count == 1, "R3 halted count", count, 1);
    wr(0, 3);
    @(negedge clk);
    chk(count == 2, "R3 resume phase", count, 2);
    repeat (2) @(negedge clk);
    wr(1, 4);
    repeat (3) @(negedge clk);
    chk(count == 2, "R4 no early step", count, 2);
    @(negedge clk);
    chk(count == 3, "R4 step after restart", count, 3);

    // R5/R8/R9 alarm without auto-reload
    wr(0, 0); wr(6, 0); wr(2, 3); wr(3, 0); wr(1, 2); wr(0, 11);
    repeat (6) @(negedge clk);
    chk(count == 3 && irq_pls == 0, "R5 not yet fired", {count[62:0], irq_pls}, {63'd3, 1'b0});
    @(negedge clk);
    chk(irq_pls == 1, "R8 pulse high", irq_pls, 1);
    chk(irq_lvl == 1, "R9 level set", irq_lvl, 1);
    @(negedge clk);
    chk(irq_pls == 0, "R8 pulse one cycle", irq_pls, 0);
    chk(count == 4, "R6 no reload when disabled", count, 4);
    wr(4, 3);
    wr(6, 0);
    chk(irq_pls == 0, "R5 disarmed after fire", irq_pls, 0);
    @(negedge clk);
    chk(irq_pls == 0, "R5 still disarmed", irq_pls, 0);
    chk(irq_lvl == 1, "R9 level held", irq_lvl, 1);
    int_clr = 1;
    @(negedge clk);
    int_clr = 0;
    chk(irq_lvl == 0, "R9 level cleared", irq_lvl, 0);

    // R6 auto-reload, R9 set beats clear
    wr(0, 0); wr(4, 10); wr(6, 0); wr(2, 12); wr(1, 2); wr(0, 15);
    repeat (4) @(negedge clk);
    chk(count == 12, "R6 reached alarm", count, 12);
    int_clr = 1;
    @(negedge clk);
    int_clr = 0;
    chk(count == 10, "R6 reloaded", count, 10);
    chk(irq_pls == 1, "R8 pulse on reload", irq_pls, 1);
    chk(irq_lvl == 1, "R9 set wins over clear", irq_lvl, 1);
    wr(0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule